// File: doc/BRIEF.md
# Dual-Clock FIFO Port Interface with Mailboxes

This block sits between two independent 36-bit data ports and an external first-in first-out storage array. Each port has its own clock and four control inputs: an active-low chip select, a direction select, an enable and a mailbox select. The block decodes these controls into a write strobe on the port-A side and a read strobe on the port-B side. The storage array, its pointers and its ready flags stay outside the block. Port B holds the word it reads from the array in an output register.

Two 36-bit mailbox registers let the ports pass single words past the FIFO. Mailbox 1 carries words from A to B, and mailbox 2 carries words from B to A. Each mailbox has an active-low flag: high means empty. A write drives the flag low, and a read from the opposite port drives it high again. The direction select on port B has the opposite sense to port A. Each port also drives an output-enable that models its three-state data drivers.

Top module: `fifo_bus_if`

## Requirements
- R1: While reset is asserted and after it is released, both mailbox flags are high (empty). Both mailboxes and the port-B output register read as zero.
- R2: `a_oe_o` is high exactly when `a_cs_n_i`=0 and `a_dir_i`=0. While it is high, `a_data_o` shows mailbox 2.
- R3: `fifo_wr_o` is high exactly when `a_cs_n_i`=0, `a_dir_i`=1, `a_en_i`=1, `a_mb_sel_i`=0 and `in_ready_i`=1. `fifo_wdata_o` equals `a_data_i`.
- R4: A port-A clock edge with `a_cs_n_i`=0, `a_dir_i`=1, `a_en_i`=1 and `a_mb_sel_i`=1 loads `a_data_i` into mailbox 1 and drives `mb1_empty_o` low. `in_ready_i` does not gate this write.
- R5: `b_oe_o` is high exactly when `b_cs_n_i`=0 and `b_dir_i`=1. While it is high, `b_data_o` shows mailbox 1 if `b_mb_sel_i`=1, and the output register if `b_mb_sel_i`=0.
- R6: `fifo_rd_o` is high exactly when `b_cs_n_i`=0, `b_dir_i`=1, `b_en_i`=1, `b_mb_sel_i`=0 and `out_ready_i`=1. On that port-B edge, the output register loads `fifo_rdata_i`.
- R7: A port-B clock edge with `b_cs_n_i`=0, `b_dir_i`=0, `b_en_i`=1 and `b_mb_sel_i`=1 loads `b_data_i` into mailbox 2 and drives `mb2_empty_o` low.
- R8: A port-B edge with `b_cs_n_i`=0, `b_dir_i`=1, `b_en_i`=1 and `b_mb_sel_i`=1 reads mailbox 1 and returns `mb1_empty_o` high. A port-A edge with `a_cs_n_i`=0, `a_dir_i`=0, `a_en_i`=1 and `a_mb_sel_i`=1 reads mailbox 2 and returns `mb2_empty_o` high.
- R9: A port with its chip select high or its enable low raises no strobe and changes no mailbox, flag or output register.
- R10: Reading an empty mailbox leaves its flag high. Writing a full mailbox replaces its data and leaves its flag low. A write and a read of the same full mailbox on one edge leave it empty, holding the new data.
- R11: A FIFO write on port A and a FIFO read on port B in the same cycle both take effect, and neither changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port-A clock |
| clk_b_i | input | 1 | Port-B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_cs_n_i | input | 1 | Port-A chip select, active low |
| a_dir_i | input | 1 | Port-A direction: 1 writes into the block, 0 drives out |
| a_en_i | input | 1 | Port-A enable |
| a_mb_sel_i | input | 1 | Port-A mailbox select |
| a_data_i | input | DATA_W | Port-A input data |
| a_data_o | output | DATA_W | Port-A output data (mailbox 2) |
| a_oe_o | output | 1 | Port-A driver enable |
| in_ready_i | input | 1 | Array has room for a write |
| fifo_wr_o | output | 1 | Write strobe to the array |
| fifo_wdata_o | output | DATA_W | Write data to the array |
| b_cs_n_i | input | 1 | Port-B chip select, active low |
| b_dir_i | input | 1 | Port-B direction: 1 drives out, 0 writes into the block |
| b_en_i | input | 1 | Port-B enable |
| b_mb_sel_i | input | 1 | Port-B mailbox select |
| b_data_i | input | DATA_W | Port-B input data |
| b_data_o | output | DATA_W | Port-B output data |
| b_oe_o | output | 1 | Port-B driver enable |
| out_ready_i | input | 1 | Array holds a word to read |
| fifo_rd_o | output | 1 | Read strobe to the array |
| fifo_rdata_i | input | DATA_W | Head word from the array |
| mb1_empty_o | output | 1 | Mailbox 1 flag, high when empty |
| mb2_empty_o | output | 1 | Mailbox 2 flag, high when empty |

## Verification
The bench builds the block at its default width of 36 bits and drives both port clocks from one source. This puts every pair of port-A and port-B operations on the same edge, including a write and a read of the same mailbox together, which reaches the R10 collision case and the R11 concurrency case on every cycle. Random words across the full 36 bits show that mailbox and register bits are neither dropped nor swapped.

// File: rtl/fbi_pkg.sv
`timescale 1ns/1ps
package fbi_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FIFO  = 2'd1,
    OP_MB_WR = 2'd2,
    OP_MB_RD = 2'd3
  } port_op_e;
endpackage

// File: rtl/fbi_port_decode.sv
`timescale 1ns/1ps
module fbi_port_decode
  import fbi_pkg::*;
#(
  parameter bit WR_DIR     = 1'b1, // dir level that means "into the block"
  parameter bit FIFO_ON_WR = 1'b1  // FIFO traffic flows in the write direction
) (
  input  logic     cs_n_i,
  input  logic     dir_i,
  input  logic     en_i,
  input  logic     mb_sel_i,
  input  logic     ready_i,
  output port_op_e op_o,
  output logic     oe_o
);
  logic wr_dir, sel;

  assign wr_dir = (dir_i == WR_DIR);
  assign sel    = !cs_n_i && en_i;
  assign oe_o   = !cs_n_i && !wr_dir;

  generate
    if (FIFO_ON_WR) begin : g_fifo_wr
      always_comb begin
        op_o = OP_IDLE;
        if (sel) begin
          if (wr_dir) op_o = mb_sel_i ? OP_MB_WR : (ready_i ? OP_FIFO : OP_IDLE);
          else if (mb_sel_i) op_o = OP_MB_RD;
        end
      end
    end else begin : g_fifo_rd
      always_comb begin
        op_o = OP_IDLE;
        if (sel) begin
          if (!wr_dir) op_o = mb_sel_i ? OP_MB_RD : (ready_i ? OP_FIFO : OP_IDLE);
          else if (mb_sel_i) op_o = OP_MB_WR;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fbi_mailbox.sv
`timescale 1ns/1ps
module fbi_mailbox #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] data_q;
  logic              wr_tog_q, rd_tog_q;

  // toggles in separate domains; equal toggles mean empty
  assign empty_o = (wr_tog_q == rd_tog_q);
  assign data_o  = data_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      wr_tog_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      if (empty_o) wr_tog_q <= ~wr_tog_q;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_tog_q <= 1'b0;
    else if (rd_i && !empty_o)  rd_tog_q <= ~rd_tog_q;
  end

  a_r4_write_loads: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_i |=> (data_o == $past(wdata_i)));
  a_r4_write_fills: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && empty_o) |=> (wr_tog_q != $past(wr_tog_q)));
  a_r10_read_empty_noop: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> $stable(rd_tog_q));
  a_r9_no_wr_stable: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(data_o));
endmodule

// File: rtl/fbi_rd_stage.sv
`timescale 1ns/1ps
module fbi_rd_stage #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic [DATA_W-1:0] mb_data_i,
  input  logic              mb_sel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (load_i) out_q <= fifo_data_i;
  end

  assign data_o = mb_sel_i ? mb_data_i : out_q;

  a_r6_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (out_q == $past(fifo_data_i)));
  a_r9_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(out_q));
endmodule

// File: rtl/fifo_bus_if.sv
`timescale 1ns/1ps
module fifo_bus_if
  import fbi_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_cs_n_i,
  input  logic              a_dir_i,
  input  logic              a_en_i,
  input  logic              a_mb_sel_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_oe_o,
  input  logic              in_ready_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  input  logic              b_cs_n_i,
  input  logic              b_dir_i,
  input  logic              b_en_i,
  input  logic              b_mb_sel_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_oe_o,
  input  logic              out_ready_i,
  output logic              fifo_rd_o,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              mb1_empty_o,
  output logic              mb2_empty_o
);
  port_op_e          a_op, b_op;
  logic [DATA_W-1:0] mb1_data, mb2_data;

  fbi_port_decode #(.WR_DIR(1'b1), .FIFO_ON_WR(1'b1)) u_dec_a (
    .cs_n_i(a_cs_n_i), .dir_i(a_dir_i), .en_i(a_en_i), .mb_sel_i(a_mb_sel_i),
    .ready_i(in_ready_i), .op_o(a_op), .oe_o(a_oe_o)
  );

  // port B direction has the opposite sense
  fbi_port_decode #(.WR_DIR(1'b0), .FIFO_ON_WR(1'b0)) u_dec_b (
    .cs_n_i(b_cs_n_i), .dir_i(b_dir_i), .en_i(b_en_i), .mb_sel_i(b_mb_sel_i),
    .ready_i(out_ready_i), .op_o(b_op), .oe_o(b_oe_o)
  );

  fbi_mailbox #(.DATA_W(DATA_W)) u_mb1 (
    .wclk_i(clk_a_i), .rclk_i(clk_b_i), .rst_ni(rst_ni),
    .wr_i(a_op == OP_MB_WR), .wdata_i(a_data_i),
    .rd_i(b_op == OP_MB_RD), .data_o(mb1_data), .empty_o(mb1_empty_o)
  );

  fbi_mailbox #(.DATA_W(DATA_W)) u_mb2 (
    .wclk_i(clk_b_i), .rclk_i(clk_a_i), .rst_ni(rst_ni),
    .wr_i(b_op == OP_MB_WR), .wdata_i(b_data_i),
    .rd_i(a_op == OP_MB_RD), .data_o(mb2_data), .empty_o(mb2_empty_o)
  );

  fbi_rd_stage #(.DATA_W(DATA_W)) u_rd (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .load_i(fifo_rd_o),
    .fifo_data_i(fifo_rdata_i), .mb_data_i(mb1_data), .mb_sel_i(b_mb_sel_i),
    .data_o(b_data_o)
  );

  assign fifo_wr_o    = (a_op == OP_FIFO);
  assign fifo_wdata_o = a_data_i;
  assign fifo_rd_o    = (b_op == OP_FIFO);
  assign a_data_o     = mb2_data;

  a_r9_a_deselect: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_cs_n_i |-> (!fifo_wr_o && !a_oe_o));
  a_r9_b_deselect: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    b_cs_n_i |-> (!fifo_rd_o && !b_oe_o));
  a_r2_oe_no_write: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_oe_o |-> !fifo_wr_o);
  a_r3_needs_ready: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    fifo_wr_o |-> (in_ready_i && a_en_i));
  a_r6_needs_ready: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    fifo_rd_o |-> (out_ready_i && b_oe_o));
  a_r8_mb1_read_empties: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    ((b_op == OP_MB_RD) && !mb1_empty_o && !(a_op == OP_MB_WR)) |=> mb1_empty_o);
endmodule

// File: tb/fifo_bus_if_tb_top.sv
`timescale 1ns/1ps
module fifo_bus_if_tb_top;
  localparam int unsigned W = 36;

  logic clk = 1'b0;
  logic rst_ni;
  logic a_cs_n, a_dir, a_en, a_mb, in_rdy;
  logic b_cs_n, b_dir, b_en, b_mb, out_rdy;
  logic [W-1:0] a_din, b_din, rdata;
  logic [W-1:0] a_dout, b_dout, wdata;
  logic a_oe, b_oe, f_wr, f_rd, e1, e2;

  int checks = 0, errors = 0;
  logic [W-1:0] m_mb1, m_mb2, m_oreg;
  logic m_e1, m_e2;

  always #2 clk = ~clk;

  fifo_bus_if #(.DATA_W(W)) dut_i (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_ni),
    .a_cs_n_i(a_cs_n), .a_dir_i(a_dir), .a_en_i(a_en), .a_mb_sel_i(a_mb),
    .a_data_i(a_din), .a_data_o(a_dout), .a_oe_o(a_oe), .in_ready_i(in_rdy),
    .fifo_wr_o(f_wr), .fifo_wdata_o(wdata),
    .b_cs_n_i(b_cs_n), .b_dir_i(b_dir), .b_en_i(b_en), .b_mb_sel_i(b_mb),
    .b_data_i(b_din), .b_data_o(b_dout), .b_oe_o(b_oe), .out_ready_i(out_rdy),
    .fifo_rd_o(f_rd), .fifo_rdata_i(rdata),
    .mb1_empty_o(e1), .mb2_empty_o(e2)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_fifo_wr();
    return !a_cs_n && a_dir && a_en && !a_mb && in_rdy;
  endfunction
  function automatic logic exp_fifo_rd();
    return !b_cs_n && b_dir && b_en && !b_mb && out_rdy;
  endfunction

  task automatic drive(input logic acs, adir, aen, amb, ardy, input logic [W-1:0] ad,
                       input logic bcs, bdir, ben, bmb, brdy, input logic [W-1:0] bd,
                       input logic [W-1:0] rd);
    a_cs_n = acs; a_dir = adir; a_en = aen; a_mb = amb; in_rdy = ardy; a_din = ad;
    b_cs_n = bcs; b_dir = bdir; b_en = ben; b_mb = bmb; out_rdy = brdy; b_din = bd;
    rdata = rd;
  endtask

  // inputs already driven after a negedge; check, then take the edge
  task automatic step();
    logic a_mbw, a_mbr, b_mbw, b_mbr, b_fifo;
    #1;
    chk("R2 a_oe", a_oe, !a_cs_n && !a_dir);
    if (a_oe) chk("R2 a_data", a_dout, m_mb2);
    chk("R3 fifo_wr", f_wr, exp_fifo_wr());
    chk("R3 wdata", wdata, a_din);
    chk("R5 b_oe", b_oe, !b_cs_n && b_dir);
    if (b_oe) chk("R5 b_data", b_dout, b_mb ? m_mb1 : m_oreg);
    chk("R6 fifo_rd", f_rd, exp_fifo_rd());
    chk("R11 both strobes", {f_wr, f_rd}, {exp_fifo_wr(), exp_fifo_rd()});
    chk("R8 e1", e1, m_e1);
    chk("R8 e2", e2, m_e2);
    @(posedge clk);
    a_mbw  = !a_cs_n && a_en && a_dir && a_mb;
    a_mbr  = !a_cs_n && a_en && !a_dir && a_mb;
    b_mbw  = !b_cs_n && b_en && !b_dir && b_mb;
    b_mbr  = !b_cs_n && b_en && b_dir && b_mb;
    b_fifo = exp_fifo_rd();
    if (a_mbw) m_mb1 = a_din;
    if (b_mbw) m_mb2 = b_din;
    m_e1 = m_e1 ? !a_mbw : b_mbr;
    m_e2 = m_e2 ? !b_mbw : a_mbr;
    if (b_fifo) m_oreg = rdata;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rnd_w();
    return {$urandom, $urandom} & {W{1'b1}};
  endfunction

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    m_mb1 = '0; m_mb2 = '0; m_oreg = '0; m_e1 = 1'b1; m_e2 = 1'b1;
    rst_ni = 1'b0;
    // port A drives out, port B drives the register
    drive(0, 0, 0, 0, 0, '0, 0, 1, 0, 0, 0, '0, '0);
    repeat (3) @(negedge clk);
    chk("R1 e1", e1, 1'b1);
    chk("R1 e2", e2, 1'b1);
    chk("R1 a_data", a_dout, '0);
    chk("R1 oreg", b_dout, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    b_mb = 1'b1; #1;
    chk("R1 mb1 zero", b_dout, '0);
    @(negedge clk);

    // R4: mailbox-1 write with in_ready low, then R8 read on B
    drive(0, 1, 1, 1, 0, 36'hA_5A5A_5A5A, 1, 0, 0, 0, 0, '0, '0); step();
    chk("R4 e1 low", e1, 1'b0);
    drive(1, 0, 0, 0, 0, '0, 0, 1, 0, 1, 0, '0, '0); #1;
    chk("R4 mb1 data", b_dout, 36'hA_5A5A_5A5A);
    // R9: enable low read leaves flag low
    step();
    chk("R9 e1 held", e1, 1'b0);
    drive(1, 0, 0, 0, 0, '0, 0, 1, 1, 1, 0, '0, '0); step();
    chk("R8 e1 high", e1, 1'b1);
    // R10: read when empty keeps flag high
    step();
    chk("R10 e1 empty read", e1, 1'b1);
    // R7: mailbox 2 write from B, overwrite while full (R10), read on A (R8)
    drive(1, 0, 0, 0, 0, '0, 0, 0, 1, 1, 0, 36'h1_2345_6789, '0); step();
    chk("R7 e2 low", e2, 1'b0);
    drive(1, 0, 0, 0, 0, '0, 0, 0, 1, 1, 0, 36'hF_EDCB_A987, '0); step();
    chk("R10 e2 still low", e2, 1'b0);
    drive(0, 0, 0, 0, 0, '0, 1, 0, 0, 0, 0, '0, '0); #1;
    chk("R10 mb2 overwritten", a_dout, 36'hF_EDCB_A987);
    drive(0, 0, 1, 1, 0, '0, 1, 0, 0, 0, 0, '0, '0); step();
    chk("R8 e2 high", e2, 1'b1);
    // R10 collision: mb1 full, write and read on one edge -> empty, new data
    drive(0, 1, 1, 1, 0, 36'h0_0000_0001, 1, 0, 0, 0, 0, '0, '0); step();
    drive(0, 1, 1, 1, 0, 36'hF_FFFF_FFFF, 0, 1, 1, 1, 0, '0, '0); step();
    chk("R10 collide e1", e1, 1'b1);
    drive(1, 0, 0, 0, 0, '0, 0, 1, 0, 1, 0, '0, '0); #1;
    chk("R10 collide data", b_dout, 36'hF_FFFF_FFFF);
    // R11: fifo write and fifo read together; R6 register load
    drive(0, 1, 1, 0, 1, 36'h3_3333_3333, 0, 1, 1, 0, 1, '0, 36'hC_CCCC_CCCC); step();
    b_mb = 1'b0; #1;
    chk("R6 oreg", b_dout, 36'hC_CCCC_CCCC);
    // R9: deselected read leaves register
    drive(1, 1, 1, 0, 1, '0, 1, 1, 1, 0, 1, '0, 36'h7_7777_7777); step();
    drive(1, 0, 0, 0, 0, '0, 0, 1, 0, 0, 0, '0, '0); #1;
    chk("R9 oreg held", b_dout, 36'hC_CCCC_CCCC);
    @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) == 0, $urandom, ($urandom % 4) != 0, $urandom, $urandom, rnd_w(),
            ($urandom % 4) == 0, $urandom, ($urandom % 4) != 0, $urandom, $urandom, rnd_w(),
            rnd_w());
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule